// File: doc/BRIEF.md
# Line-Split DMA Request Issuer

This block takes one transfer command at a time: a direction, a start byte address, a byte length and an optional completion delay. It cuts the transfer into memory requests, none of which crosses a cache-line boundary. The first piece runs from the start address up to the next line edge. Every middle piece is a whole line. The final piece carries whatever bytes are left. The pieces go into a small queue, and only the queue head is offered on the request channel. On a write, each piece also reports the offset into the caller's data buffer where its bytes begin.

The request channel uses valid/ready with a retry rule. When the channel accepts a request, the block stays quiet for one cycle before it offers the next one. When the channel refuses a request, the block withdraws it and waits for a retry pulse, then offers the same request again.

Each response echoes the byte count of the request it answers. The block adds these echoed counts, not line-rounded sizes. When the total reaches the transfer length, it raises a one-cycle done pulse, after the programmed number of extra cycles. A drained flag shows when no piece is queued or in flight.

Top module: `dma_line_splitter`

## Requirements
- R1: Every request stays inside one line of LINE_BYTES bytes (64 by default) and has a nonzero size. The first piece ends at the first line edge after the start address, middle pieces are full lines, and the last piece holds the remainder. The pieces come out in ascending address order and their sizes add up to the length.
- R2: req_offset equals the number of bytes of the current transfer issued before that piece, so it is 0 for the first piece. req_write repeats the command's cmd_write bit.
- R3: A request is taken in a cycle where req_valid and req_ready are both high. Requests appear one at a time, in queue order.
- R4: A refused request is withdrawn: req_valid is low from the next cycle until a req_retry pulse is seen. In the cycle after that pulse, the same request (same address) is offered again.
- R5: After a request is taken, req_valid is low for the following cycle.
- R6: drained is high only when no piece is queued and none is waiting for a response. It is low while any accepted request still lacks its response.
- R7: done is a one-cycle pulse. With the command's delay D, it appears in the cycle D+1 cycles after the cycle whose response brings the byte total up to the length.
- R8: A response whose byte count would push the running total above the length raises rsp_err for one cycle, in the following cycle. That count is not added to the total.
- R9: cmd_ready is high only when nothing is being cut, nothing is outstanding and no done is pending. It stays low for the whole of a transfer and is high in the done cycle. When the queue is full, cutting stalls without losing pieces.
- R10: A zero-length command issues no requests and produces done in the cycle after it is accepted.
- R11: After reset: cmd_ready=1, req_valid=0, drained=1, done=0, rsp_err=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Transfer command present |
| cmd_ready | output | 1 | Block idle, command taken when valid |
| cmd_write | input | 1 | 1 = write transfer, 0 = read |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_len | input | LEN_W | Transfer length in bytes |
| cmd_delay | input | DLY_W | Extra cycles before the done pulse |
| req_valid | output | 1 | Head request offered |
| req_ready | input | 1 | Channel takes the offered request |
| req_retry | input | 1 | Channel invites a refused request back |
| req_write | output | 1 | Direction of the offered request |
| req_addr | output | ADDR_W | Byte address of the offered request |
| req_size | output | log2(LINE_BYTES)+1 | Byte count of the offered request |
| req_offset | output | LEN_W | Offset of the piece in the transfer buffer |
| rsp_valid | input | 1 | One response arrives |
| rsp_bytes | input | log2(LINE_BYTES)+1 | Byte count of the request being answered |
| drained | output | 1 | Nothing queued or in flight |
| done | output | 1 | Transfer complete pulse |
| rsp_err | output | 1 | Response overran the transfer length |

## Verification
The embedded checks rely on two things about the inputs: every response carries a nonzero byte count, and no response arrives while nothing is outstanding. The stimulus meets both. It answers only requests that were accepted in an earlier cycle, answers them in order, and echoes each request's own size. The one exception is a single directed case, which sends an oversized echo on purpose to cover the overrun path. Random ready, random retry gaps and random response latencies go with random addresses, lengths and delays, including lengths long enough to fill the queue.

// File: rtl/dma_line_splitter.sv
module dma_line_splitter #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int LINE_BYTES = 64,
  parameter int QDEPTH     = 4,
  parameter int DLY_W      = 8,
  localparam int LB        = $clog2(LINE_BYTES),
  localparam int SZ_W      = LB + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [DLY_W-1:0]  cmd_delay,
  output logic              req_valid,
  input  logic              req_ready,
  input  logic              req_retry,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [SZ_W-1:0]   req_size,
  output logic [LEN_W-1:0]  req_offset,
  input  logic              rsp_valid,
  input  logic [SZ_W-1:0]   rsp_bytes,
  output logic              drained,
  output logic              done,
  output logic              rsp_err
);
  localparam int QA = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;

  logic              cutting, wr_mode, in_retry, gap, dly_on, done_r, err_r;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  rem, issued, total, acc;
  logic [DLY_W-1:0]  delay_r, dcnt;
  logic [LEN_W:0]    outst;

  logic [ADDR_W-1:0] q_addr [QDEPTH];
  logic [SZ_W-1:0]   q_size [QDEPTH];
  logic [LEN_W-1:0]  q_off  [QDEPTH];
  logic [QA-1:0]     wp, rp;
  logic [QA:0]       qcnt;

  logic [SZ_W-1:0]   room, piece;
  logic [LEN_W-1:0]  room_w;
  logic [LEN_W:0]    sum;
  logic              push, accept, refuse, cmd_go, over, hit, rsp_dec, last;

  assign room    = SZ_W'(LINE_BYTES) - SZ_W'(cur_addr[LB-1:0]);
  assign room_w  = LEN_W'(room);
  assign last    = rem <= room_w;
  assign piece   = last ? rem[SZ_W-1:0] : room;
  assign push    = cutting && (qcnt != (QA+1)'(QDEPTH));

  assign req_valid  = (qcnt != '0) && !in_retry && !gap;
  assign req_addr   = q_addr[rp];
  assign req_size   = q_size[rp];
  assign req_offset = q_off[rp];
  assign req_write  = wr_mode;
  assign accept     = req_valid && req_ready;
  assign refuse     = req_valid && !req_ready;

  assign cmd_ready = !cutting && (outst == '0) && !dly_on;
  assign cmd_go    = cmd_valid && cmd_ready;

  assign sum     = {1'b0, acc} + (LEN_W+1)'(rsp_bytes);
  assign over    = rsp_valid && (sum > {1'b0, total});
  assign hit     = rsp_valid && !over && (sum == {1'b0, total});
  assign rsp_dec = rsp_valid && (outst != '0);

  assign drained = outst == '0;
  assign done    = done_r;
  assign rsp_err = err_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cutting <= 1'b0; wr_mode <= 1'b0; cur_addr <= '0; rem <= '0; issued <= '0;
      total <= '0; delay_r <= '0;
    end else if (cmd_go) begin
      cutting  <= cmd_len != '0;
      wr_mode  <= cmd_write;
      cur_addr <= cmd_addr;
      rem      <= cmd_len;
      issued   <= '0;
      total    <= cmd_len;
      delay_r  <= cmd_delay;
    end else if (push) begin
      cur_addr <= cur_addr + ADDR_W'(piece);
      rem      <= rem - LEN_W'(piece);
      issued   <= issued + LEN_W'(piece);
      if (last) cutting <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      q_addr[wp] <= cur_addr;
      q_size[wp] <= piece;
      q_off[wp]  <= issued;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; qcnt <= '0;
    end else begin
      if (push)   wp <= (wp == QA'(QDEPTH-1)) ? '0 : wp + 1'b1;
      if (accept) rp <= (rp == QA'(QDEPTH-1)) ? '0 : rp + 1'b1;
      qcnt <= qcnt + (QA+1)'(push) - (QA+1)'(accept);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_retry <= 1'b0; gap <= 1'b0;
    end else begin
      gap <= accept;
      if (refuse)         in_retry <= 1'b1;
      else if (req_retry) in_retry <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) outst <= '0;
    else        outst <= outst + (LEN_W+1)'(push) - (LEN_W+1)'(rsp_dec);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0; dly_on <= 1'b0; dcnt <= '0; done_r <= 1'b0; err_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      err_r  <= over;
      if (cmd_go) begin
        acc <= '0;
        if (cmd_len == '0) done_r <= 1'b1;
      end else if (rsp_valid && !over) begin
        acc <= sum[LEN_W-1:0];
      end
      if (hit) begin
        if (delay_r == '0) done_r <= 1'b1;
        else begin
          dly_on <= 1'b1;
          dcnt   <= delay_r;
        end
      end else if (dly_on) begin
        dcnt <= dcnt - 1'b1;
        if (dcnt == DLY_W'(1)) begin
          done_r <= 1'b1;
          dly_on <= 1'b0;
        end
      end
    end
  end

  // R1
  line_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_size != '0) &&
      (({1'b0, req_addr[LB-1:0]} + req_size) <= SZ_W'(LINE_BYTES)));
  // R4
  refuse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refuse |=> !req_valid && $stable(req_addr));
  // R4
  retry_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_retry && !req_retry) |=> !req_valid);
  // R5
  send_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_valid);
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !req_valid);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);
  // R8
  err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> $past(rsp_valid));
  // R6
  rsp_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_bytes != '0) && !drained);
endmodule

// File: tb/dma_line_splitter_tb.sv
module dma_line_splitter_tb;
  localparam int LINE = 64;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [31:0] cmd_addr = '0;
  logic [15:0] cmd_len = '0;
  logic [7:0]  cmd_delay = '0;
  logic        req_ready = 1'b0, req_retry = 1'b0, rsp_valid = 1'b0;
  logic [6:0]  rsp_bytes = '0;
  logic        cmd_ready, req_valid, req_write, drained, done, rsp_err;
  logic [31:0] req_addr;
  logic [6:0]  req_size;
  logic [15:0] req_offset;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int e_addr [0:63];
  int e_size [0:63];
  int e_off  [0:63];
  int n_exp;
  int rq [0:63];
  int rq_h, rq_t;

  dma_line_splitter u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_delay(cmd_delay),
    .req_valid(req_valid), .req_ready(req_ready), .req_retry(req_retry),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size), .req_offset(req_offset),
    .rsp_valid(rsp_valid), .rsp_bytes(rsp_bytes), .drained(drained), .done(done),
    .rsp_err(rsp_err));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, 190000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic void plan_pieces(input int a, input int l);
    int rem = l, pos = a, off = 0;
    n_exp = 0;
    while (rem > 0) begin
      int room = LINE - (pos % LINE);
      int s = (rem < room) ? rem : room;
      e_addr[n_exp] = pos; e_size[n_exp] = s; e_off[n_exp] = off;
      n_exp++; pos += s; off += s; rem -= s;
    end
  endfunction

  task automatic send_cmd(input int a, input int l, input bit w, input int d);
    check(done == 1'b0, "R7 pulse width", done, 0);
    check(cmd_ready == 1'b1, "R9 idle before cmd", cmd_ready, 1);
    cmd_valid = 1'b1; cmd_addr = a; cmd_len = l[15:0]; cmd_write = w; cmd_delay = d[7:0];
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_xfer(input int a, input int l, input bit w, input int d);
    int idx = 0, sum = 0, outb = 0, t = 0, exp_done = -1, retry_at = 0, ref_addr = 0;
    bit refused = 0, retry_sent = 0, prev_acc = 0, fin = 0;
    plan_pieces(a, l);
    rq_h = 0; rq_t = 0;
    send_cmd(a, l, w, d);
    if (l == 0) begin
      check(done == 1'b1, "R10 zero-length done", done, 1);
      check(req_valid == 1'b0, "R10 no request", req_valid, 0);
      @(negedge clk);
      check(done == 1'b0, "R7 single pulse", done, 0);
      check(req_valid == 1'b0, "R10 still no request", req_valid, 0);
      return;
    end
    while (!fin && t < 5000) begin
      if (prev_acc) check(req_valid == 1'b0, "R5 gap after send", req_valid, 0);
      if (retry_sent) begin
        check(req_valid == 1'b1 && int'(req_addr) == ref_addr, "R4 re-offer same request",
              int'(req_addr), ref_addr);
        refused = 0;
      end else if (refused) check(req_valid == 1'b0, "R4 withdrawn until retry", req_valid, 0);
      if (outb > 0) check(drained == 1'b0, "R6 not drained while in flight", drained, 0);
      if (done) begin
        check(t == exp_done, "R7 done timing", t, exp_done);
        check(cmd_ready == 1'b1, "R9 ready at done", cmd_ready, 1);
        check(drained == 1'b1, "R6 drained at done", drained, 1);
        check(idx == n_exp, "R1 piece count", idx, n_exp);
        fin = 1;
      end else begin
        if (t == exp_done) check(0, "R7 done missing", 0, 1);
        check(cmd_ready == 1'b0, "R9 busy during transfer", cmd_ready, 0);
      end
      rsp_valid = 1'b0; req_ready = 1'b0; req_retry = 1'b0;
      retry_sent = 0; prev_acc = 0;
      if (!fin) begin
        if (rq_h != rq_t && ($urandom % 3) != 0) begin
          rsp_valid = 1'b1; rsp_bytes = rq[rq_h][6:0]; sum += rq[rq_h]; rq_h++; outb--;
          if (sum == l) exp_done = t + d + 1;
        end
        if (refused && t >= retry_at) begin
          req_retry = 1'b1; retry_sent = 1;
        end
        if (req_valid) begin
          if (($urandom % 4) != 0) begin
            req_ready = 1'b1;
            check(idx < n_exp && int'(req_addr) == e_addr[idx] && int'(req_size) == e_size[idx],
                  "R1/R3 piece addr", int'(req_addr), e_addr[idx]);
            check(int'(req_offset) == e_off[idx] && req_write == w, "R2 offset",
                  int'(req_offset), e_off[idx]);
            rq[rq_t] = int'(req_size); rq_t++; outb++; idx++; prev_acc = 1;
          end else begin
            refused = 1; ref_addr = int'(req_addr); retry_at = t + 1 + int'($urandom % 3);
          end
        end
      end
      t++;
      @(negedge clk);
    end
    rsp_valid = 1'b0; req_ready = 1'b0; req_retry = 1'b0;
    if (!fin) check(0, "R7 transfer hung", t, 5000);
  endtask

  task automatic overrun_case();
    int w8 = 0;
    send_cmd(8, 8, 1'b0, 0);
    while (!req_valid && w8 < 20) begin @(negedge clk); w8++; end
    check(int'(req_size) == 8, "R1 single in-line piece", int'(req_size), 8);
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    rsp_valid = 1'b1; rsp_bytes = 7'd12;
    @(negedge clk);
    rsp_valid = 1'b0;
    check(rsp_err == 1'b1, "R8 overrun flagged", rsp_err, 1);
    check(done == 1'b0, "R8 no done on overrun", done, 0);
    @(negedge clk);
    check(rsp_err == 1'b0, "R8 one-cycle flag", rsp_err, 0);
    check(drained == 1'b1, "R6 drained after last response", drained, 1);
    for (int k = 0; k < 5; k++) begin
      check(done == 1'b0, "R8 bytes not counted", done, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1'b1, "R11 cmd_ready", cmd_ready, 1);
    check(req_valid == 1'b0, "R11 req_valid", req_valid, 0);
    check(drained == 1'b1, "R11 drained", drained, 1);
    check(done == 1'b0 && rsp_err == 1'b0, "R11 done/err", done, 0);

    do_xfer(64, 64, 1'b0, 0);
    do_xfer(60, 10, 1'b1, 0);
    do_xfer(5, 200, 1'b1, 2);
    do_xfer(130, 3, 1'b0, 3);
    do_xfer(0, 0, 1'b0, 4);
    do_xfer(1, 630, 1'b1, 1);
    overrun_case();
    do_xfer(100, 40, 1'b0, 0);
    for (int i = 0; i < 40; i++) begin
      int a = int'($urandom % 1024);
      int l = (($urandom % 8) == 0) ? 0 : int'($urandom % 400) + 1;
      do_xfer(a, l, 1'(($urandom % 2)), int'($urandom % 4));
    end
    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule